// File: doc/BRIEF.md
# Processor Interrupt Interface

This block links an interrupt distributor to one processor. Each cycle the distributor offers the best pending interrupt: an ID, a priority and a group. The interface decides whether that offer may reach the processor and drives the matching active-low request line. Group 0 interrupts go to the fast line and group 1 interrupts go to the normal line. An offer is passed on only when three conditions hold: the interface is enabled, the offer beats the priority mask, and it beats the priority of the interrupt now being handled. A lower numeric priority value means a more urgent interrupt.

Software uses an acknowledge read and an end-of-interrupt write. The acknowledge read returns the offered ID. It also sends an acknowledge event back to the distributor, which moves that interrupt from pending to active. The priority of that interrupt is then loaded into a single running-priority register. From then on, only strictly more urgent offers raise a request. When software writes the same ID to the end-of-interrupt port, the interrupt is marked complete, the distributor is told, and the running priority returns to idle. An acknowledge issued while nothing is eligible returns the reserved value 1023 and changes nothing.

Top module: `cpu_irq_if`

## Requirements
- R1: After reset both request lines are high, the running priority reads 0xFF, the acknowledge data reads 1023, the enable is off and the mask is 0x00.
- R2: An eligible offer of group 0 drives `n_fiq` low and one of group 1 drives `n_irq` low. The line follows the offer one clock later, and the other line stays high.
- R3: While the interface enable is 0, both request lines stay high whatever the distributor offers.
- R4: An offer is signalled only if its priority value is numerically less than the priority mask. A value equal to or above the mask is never signalled.
- R5: An acknowledge read of an eligible offer returns its ID on `ack_data`, with `ack_valid` high, one clock later. In that same cycle `dist_ack` pulses with the same ID on `dist_ack_id`.
- R6: After an acknowledge, `run_prio` holds the priority of the acknowledged interrupt. A later offer raises a request only if its priority value is strictly below `run_prio`. A later acknowledge replaces the active record.
- R7: An acknowledge read with no eligible offer returns 1023. It produces no `dist_ack` and leaves `run_prio` unchanged.
- R8: An end-of-interrupt write whose ID equals the active ID pulses `dist_eoi` with that ID one clock later and returns `run_prio` to 0xFF. Offers of any priority below the mask may then be signalled again.
- R9: An end-of-interrupt write whose ID differs from the active ID, or that arrives with nothing active, produces no `dist_eoi` and leaves `run_prio` unchanged.
- R10: If a more urgent offer is present right after an acknowledge, the request line stays low with no high cycle between the two interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_valid | input | 1 | Distributor has a pending offer |
| off_id | input | 10 | ID of the offered interrupt |
| off_prio | input | 8 | Priority of the offer, lower is more urgent |
| off_grp | input | 1 | Group of the offer: 0 fast line, 1 normal line |
| en_wr | input | 1 | Write strobe for the interface enable |
| en_wdata | input | 1 | New interface enable value |
| mask_wr | input | 1 | Write strobe for the priority mask |
| mask_wdata | input | 8 | New priority mask value |
| ack_rd | input | 1 | Acknowledge read strobe |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_wdata | input | 10 | ID written to end-of-interrupt |
| n_irq | output | 1 | Active-low normal interrupt request |
| n_fiq | output | 1 | Active-low fast interrupt request |
| ack_data | output | 10 | Result of the last acknowledge read |
| ack_valid | output | 1 | Pulses when ack_data is fresh |
| run_prio | output | 8 | Running priority, 0xFF when idle |
| dist_ack | output | 1 | Acknowledge event to the distributor |
| dist_ack_id | output | 10 | ID carried by dist_ack |
| dist_eoi | output | 1 | Completion event to the distributor |
| dist_eoi_id | output | 10 | ID carried by dist_eoi |

## Verification
The hardest case to reach is the seamless handover after an acknowledge. The request line must stay low across the acknowledge edge while the running priority changes underneath it. The bench plays the distributor for this. In the cycle right after the acknowledge edge it replaces the offer with a more urgent one, then samples the fast line on both sides of that change. The bench also holds an interrupt active while it sends equal-priority offers, less urgent offers and mismatched completion writes, so the running-priority filter is tested from both directions before the matching completion releases it.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
    typedef enum logic {
        GRP_FAST   = 1'b0,
        GRP_NORMAL = 1'b1
    } irq_grp_e;

    localparam int NUM_GRP = 2;
endpackage

// File: rtl/cpu_irq_gate.sv
module cpu_irq_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              en,
    input  logic              valid,
    input  logic [PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0] mask,
    input  logic [PRIO_W-1:0] run_prio,
    output logic              elig
);
    always_comb begin
        elig = en && valid && (prio < mask) && (prio < run_prio);
    end
endmodule

// File: rtl/cpu_irq_lines.sv
module cpu_irq_lines
    import cpu_irq_pkg::*;
#(
    parameter int NGRP = NUM_GRP
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            elig,
    input  irq_grp_e        grp,
    output logic [NGRP-1:0] n_line
);
    for (genvar g = 0; g < NGRP; g++) begin : g_line
        logic line_d, line_q;

        always_comb begin
            line_d = !(elig && (int'(grp) == g));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= 1'b1;
            else        line_q <= line_d;
        end

        assign n_line[g] = line_q;
    end
endmodule

// File: rtl/cpu_irq_track.sv
module cpu_irq_track #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              elig,
    input  logic [ID_W-1:0]   off_id,
    input  logic [PRIO_W-1:0] off_prio,
    input  logic              ack_rd,
    input  logic              eoi_wr,
    input  logic [ID_W-1:0]   eoi_wdata,
    output logic [ID_W-1:0]   ack_data,
    output logic              ack_valid,
    output logic [PRIO_W-1:0] run_prio,
    output logic              dist_ack,
    output logic              dist_eoi,
    output logic [ID_W-1:0]   dist_eoi_id
);
    localparam logic [ID_W-1:0]   SPURIOUS  = '1;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    typedef struct packed {
        logic              act_vld;
        logic [ID_W-1:0]   act_id;
        logic [PRIO_W-1:0] rpr;
        logic [ID_W-1:0]   rd_data;
        logic              rd_vld;
        logic              ack_evt;
        logic              eoi_evt;
        logic [ID_W-1:0]   eoi_id;
    } trk_t;

    trk_t st_d, st_q;
    logic take_ack, take_eoi;

    always_comb begin
        take_ack = ack_rd && elig;
        take_eoi = eoi_wr && !ack_rd && st_q.act_vld && (eoi_wdata == st_q.act_id);

        st_d         = st_q;
        st_d.rd_vld  = ack_rd;
        st_d.ack_evt = take_ack;
        st_d.eoi_evt = take_eoi;
        if (ack_rd) begin
            st_d.rd_data = take_ack ? off_id : SPURIOUS;
        end
        if (take_ack) begin
            st_d.act_vld = 1'b1;
            st_d.act_id  = off_id;
            st_d.rpr     = off_prio;
        end else if (take_eoi) begin
            st_d.act_vld = 1'b0;
            st_d.rpr     = IDLE_PRIO;
            st_d.eoi_id  = st_q.act_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.rpr     <= IDLE_PRIO;
            st_q.rd_data <= SPURIOUS;
        end else begin
            st_q <= st_d;
        end
    end

    assign ack_data    = st_q.rd_data;
    assign ack_valid   = st_q.rd_vld;
    assign run_prio    = st_q.rpr;
    assign dist_ack    = st_q.ack_evt;
    assign dist_eoi    = st_q.eoi_evt;
    assign dist_eoi_id = st_q.eoi_id;

    // R7
    ack_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !elig) |=> (ack_data == SPURIOUS) && !dist_ack && $stable(run_prio));

    // R8
    eoi_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_eoi |-> (run_prio == IDLE_PRIO));

    // R9
    eoi_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && !ack_rd && !(st_q.act_vld && eoi_wdata == st_q.act_id)) |=> !dist_eoi && $stable(run_prio));
endmodule

// File: rtl/cpu_irq_if.sv
module cpu_irq_if
    import cpu_irq_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              off_valid,
    input  logic [ID_W-1:0]   off_id,
    input  logic [PRIO_W-1:0] off_prio,
    input  logic              off_grp,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              mask_wr,
    input  logic [PRIO_W-1:0] mask_wdata,
    input  logic              ack_rd,
    input  logic              eoi_wr,
    input  logic [ID_W-1:0]   eoi_wdata,
    output logic              n_irq,
    output logic              n_fiq,
    output logic [ID_W-1:0]   ack_data,
    output logic              ack_valid,
    output logic [PRIO_W-1:0] run_prio,
    output logic              dist_ack,
    output logic [ID_W-1:0]   dist_ack_id,
    output logic              dist_eoi,
    output logic [ID_W-1:0]   dist_eoi_id
);
    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic elig;
    logic [NUM_GRP-1:0] n_line;

    always_comb begin
        cfg_d = cfg_q;
        if (en_wr)   cfg_d.en   = en_wdata;
        if (mask_wr) cfg_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    cpu_irq_gate #(.PRIO_W(PRIO_W)) u_gate (
        .en       (cfg_q.en),
        .valid    (off_valid),
        .prio     (off_prio),
        .mask     (cfg_q.mask),
        .run_prio (run_prio),
        .elig     (elig)
    );

    cpu_irq_lines #(.NGRP(NUM_GRP)) u_lines (
        .clk    (clk),
        .rst_n  (rst_n),
        .elig   (elig),
        .grp    (irq_grp_e'(off_grp)),
        .n_line (n_line)
    );

    cpu_irq_track #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .elig        (elig),
        .off_id      (off_id),
        .off_prio    (off_prio),
        .ack_rd      (ack_rd),
        .eoi_wr      (eoi_wr),
        .eoi_wdata   (eoi_wdata),
        .ack_data    (ack_data),
        .ack_valid   (ack_valid),
        .run_prio    (run_prio),
        .dist_ack    (dist_ack),
        .dist_eoi    (dist_eoi),
        .dist_eoi_id (dist_eoi_id)
    );

    assign n_fiq       = n_line[int'(GRP_FAST)];
    assign n_irq       = n_line[int'(GRP_NORMAL)];
    assign dist_ack_id = ack_data;

    // R3
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |=> (n_irq && n_fiq));

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(n_irq == 1'b0 && n_fiq == 1'b0));

    // R4
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_valid && off_prio >= cfg_q.mask) |=> (n_irq && n_fiq));

    // R5
    ack_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dist_ack |-> (ack_valid && dist_ack_id == ack_data));
endmodule

// File: tb/cpu_irq_if_tb.sv
module cpu_irq_if_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       off_valid = 1'b0;
    logic [9:0] off_id = '0;
    logic [7:0] off_prio = '0;
    logic       off_grp = 1'b0;
    logic       en_wr = 1'b0, en_wdata = 1'b0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ack_rd = 1'b0;
    logic       eoi_wr = 1'b0;
    logic [9:0] eoi_wdata = '0;
    logic       n_irq, n_fiq, ack_valid, dist_ack, dist_eoi;
    logic [9:0] ack_data, dist_ack_id, dist_eoi_id;
    logic [7:0] run_prio;

    int checks = 0;
    int failures = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cpu_irq_if u_dut (
        .clk(clk), .rst_n(rst_n), .off_valid(off_valid), .off_id(off_id),
        .off_prio(off_prio), .off_grp(off_grp), .en_wr(en_wr), .en_wdata(en_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .ack_rd(ack_rd),
        .eoi_wr(eoi_wr), .eoi_wdata(eoi_wdata), .n_irq(n_irq), .n_fiq(n_fiq),
        .ack_data(ack_data), .ack_valid(ack_valid), .run_prio(run_prio),
        .dist_ack(dist_ack), .dist_ack_id(dist_ack_id), .dist_eoi(dist_eoi),
        .dist_eoi_id(dist_eoi_id)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic offer(input int id, input int prio, input bit grp);
        off_valid = 1'b1; off_id = 10'(id); off_prio = 8'(prio); off_grp = grp;
    endtask

    task automatic do_ack(input int exp_id);
        exp_q.push_back(exp_id);
        ack_rd = 1'b1;
        tick();
        ack_rd = 1'b0;
    endtask

    task automatic do_eoi(input int id);
        eoi_wr = 1'b1; eoi_wdata = 10'(id);
        tick();
        eoi_wr = 1'b0;
    endtask

    // scoreboard monitor (R5, R7)
    always @(posedge clk) begin
        #2;
        if (ack_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected ack", int'(ack_data), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(int'(ack_data) == e, "R5/R7 ack_data", int'(ack_data), e);
                chk(dist_ack == (e != 1023), "R5/R7 dist_ack", int'(dist_ack), int'(e != 1023));
                if (e != 1023)
                    chk(int'(dist_ack_id) == e, "R5 dist_ack_id", int'(dist_ack_id), e);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        chk(n_irq && n_fiq, "R1 lines", int'({n_irq, n_fiq}), 3);
        chk(run_prio == 8'hFF, "R1 run_prio", int'(run_prio), 255);
        chk(ack_data == 10'd1023, "R1 ack_data", int'(ack_data), 1023);
        rst_n = 1'b1;
        tick();
        offer(40, 8'h10, 1'b1);
        tick(); tick();
        chk(n_irq && n_fiq, "R1 disabled after reset", int'({n_irq, n_fiq}), 3);

        en_wr = 1'b1; en_wdata = 1'b1; mask_wr = 1'b1; mask_wdata = 8'hF0;
        tick();
        en_wr = 1'b0; mask_wr = 1'b0;
        offer(40, 8'h80, 1'b1);
        tick();
        chk(!n_irq && n_fiq, "R2 group1 to n_irq", int'({n_irq, n_fiq}), 1);
        offer(41, 8'h80, 1'b0);
        tick();
        chk(n_irq && !n_fiq, "R2 group0 to n_fiq", int'({n_irq, n_fiq}), 2);

        en_wr = 1'b1; en_wdata = 1'b0;
        tick();
        en_wr = 1'b0;
        tick();
        chk(n_irq && n_fiq, "R3 disabled quiet", int'({n_irq, n_fiq}), 3);
        en_wr = 1'b1; en_wdata = 1'b1;
        tick();
        en_wr = 1'b0;

        offer(42, 8'hF0, 1'b1);
        tick(); tick();
        chk(n_irq, "R4 prio equal to mask blocked", int'(n_irq), 1);
        offer(42, 8'hEF, 1'b1);
        tick();
        chk(!n_irq, "R4 prio below mask passes", int'(n_irq), 0);

        offer(50, 8'h40, 1'b1);
        tick();
        do_ack(50);
        offer(51, 8'h40, 1'b1);
        chk(run_prio == 8'h40, "R6 run_prio loaded", int'(run_prio), 64);
        tick(); tick();
        chk(n_irq, "R6 equal prio not signalled", int'(n_irq), 1);
        offer(52, 8'h30, 1'b1);
        tick();
        chk(!n_irq, "R6 higher prio signalled", int'(n_irq), 0);

        offer(53, 8'h50, 1'b1);
        tick();
        do_ack(1023);
        chk(run_prio == 8'h40, "R7 run_prio unchanged", int'(run_prio), 64);

        do_eoi(99);
        chk(!dist_eoi, "R9 mismatched eoi", int'(dist_eoi), 0);
        chk(run_prio == 8'h40, "R9 run_prio kept", int'(run_prio), 64);
        chk(n_irq, "R9 still filtered", int'(n_irq), 1);

        do_eoi(50);
        chk(dist_eoi && dist_eoi_id == 10'd50, "R8 eoi event", int'(dist_eoi_id), 50);
        chk(run_prio == 8'hFF, "R8 run_prio idle", int'(run_prio), 255);
        tick();
        chk(!dist_eoi, "R8 eoi single pulse", int'(dist_eoi), 0);
        chk(!n_irq, "R8 pending now signalled", int'(n_irq), 0);
        do_ack(53);
        offer(53, 8'h50, 1'b1);
        off_valid = 1'b0;
        do_eoi(53);
        chk(run_prio == 8'hFF, "R8 idle again", int'(run_prio), 255);

        do_eoi(53);
        chk(!dist_eoi, "R9 eoi with nothing active", int'(dist_eoi), 0);

        offer(60, 8'h20, 1'b0);
        tick();
        chk(!n_fiq, "R10 first request", int'(n_fiq), 0);
        do_ack(60);
        offer(61, 8'h10, 1'b0);
        chk(!n_fiq, "R10 low across ack", int'(n_fiq), 0);
        tick();
        chk(!n_fiq, "R10 low for next", int'(n_fiq), 0);
        do_ack(61);
        chk(run_prio == 8'h10, "R6 second ack replaces record", int'(run_prio), 16);
        off_valid = 1'b0;
        do_eoi(60);
        chk(!dist_eoi, "R9 old id ignored", int'(dist_eoi), 0);
        do_eoi(61);
        chk(dist_eoi && dist_eoi_id == 10'd61, "R8 eoi newest", int'(dist_eoi_id), 61);

        tick(); tick();
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule